// File: doc/BRIEF.md
# Black-Level Clamp Pulse Generator

This block drives the black-level clamp of a video capture front end. In internal mode it waits a programmed number of pixel clocks after the trailing (falling) edge of the active-high horizontal sync input. It then raises the clamp for a programmed number of clocks. In external mode the clamp follows a board-level clamp pin instead. The pin's active level is either forced by configuration or inferred from the level the pin sits at most of the time.

A second output gives a one-clock strobe that lets an auto-offset loop take an update. The strobe follows the end of a clamp window, at a chosen cadence: every clamp, every 16th clamp, every 64th clamp, or the first clamp after each vertical sync strobe. The strobe runs only while auto-offset is enabled. It fires either once per enable or continuously.

All configuration fields are static inputs held by an upstream register file. Suggested reset values are a placement of 8, a duration of 32, polarity select high, and the per-vsync cadence.

Top module: `clamp_pulse_gen`

## Requirements
- R1: In internal mode (`src_ext_i`=0), if the hsync trailing edge is first sampled at rising clock edge E, `clamp_o` is high from edge E+P, where P=`place_i`. P=0 raises it at edge E itself.
- R2: An internal clamp stays high for exactly D=`dur_i` clock cycles and then falls.
- R3: With `dur_i`=0 a trailing edge produces no clamp and does not advance the cadence count.
- R4: A trailing edge that arrives while a clamp is pending or active cancels it and restarts the placement count from the new edge.
- R5: In external mode with `ext_pol_ovr_i`=1, `clamp_o` is high one clock after the pin is sampled at its active level. The active level is high if `ext_pol_high_i`=1 and low if it is 0.
- R6: In external mode with `ext_pol_ovr_i`=0, the active level is the opposite of the level the pin has mostly held. A pin held low for 64+ clocks reads as active high; a pin held high for 64+ clocks reads as active low.
- R7: `offset_upd_o` is a single-cycle pulse, high in the cycle after an internal clamp falls (edge E+P+D). It never fires while `ao_en_i`=0. External clamp windows also count as clamp ends.
- R8: `ao_cadence_i` 00 strobes on every clamp end, 01 on every 16th, 10 on every 64th. Counting restarts when `ao_en_i` goes low.
- R9: `ao_cadence_i` 11 strobes on the first clamp end after each `vsync_i` strobe, and on no other.
- R10: With `ao_hold_i`=0 only one strobe is given per enable period. Dropping and raising `ao_en_i` re-arms it. With `ao_hold_i`=1 strobes repeat.
- R11: During and right after reset, `clamp_o` and `offset_upd_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| hsync_i | input | 1 | Horizontal sync, active high, synchronous |
| vsync_i | input | 1 | Vertical sync strobe, one cycle |
| ext_clamp_i | input | 1 | External clamp pin |
| place_i | input | CNT_W | Clocks from hsync trailing edge to clamp start |
| dur_i | input | CNT_W | Clamp length in clocks |
| src_ext_i | input | 1 | 1 selects the external clamp pin |
| ext_pol_ovr_i | input | 1 | 1 forces the external polarity from ext_pol_high_i |
| ext_pol_high_i | input | 1 | Forced polarity: 1 active high, 0 active low |
| ao_en_i | input | 1 | Auto-offset enable |
| ao_hold_i | input | 1 | 1 continuous updates, 0 one update per enable |
| ao_cadence_i | input | 2 | Update cadence code |
| clamp_o | output | 1 | Clamp pulse, active high |
| offset_upd_o | output | 1 | Auto-offset update strobe |

## Verification
Inputs change on the falling clock edge and outputs are read on the following falling edge. The value read at the j-th falling edge after the trailing edge therefore reflects state after rising edge E+j. The bench expects the clamp over j in [P, P+D) and the internal update strobe at exactly j=P+D, and compares every cycle of that span. External clamp levels are due one clock after the pin changes. Cadence results are counted strobes, read only after every window of a burst has closed plus margin, so a late or early strobe still changes the count.

// File: rtl/clamp_pkg.sv
package clamp_pkg;
  typedef enum logic [1:0] {
    CAD_EVERY = 2'b00,
    CAD_DIV_A = 2'b01,
    CAD_DIV_B = 2'b10,
    CAD_VSYNC = 2'b11
  } cadence_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ACTIVE
  } clamp_st_e;

  // suggested register-file reset values
  localparam int unsigned RST_PLACE   = 8;
  localparam int unsigned RST_DUR     = 32;
  localparam logic        RST_POL_HI  = 1'b1;
  localparam logic [1:0]  RST_CADENCE = 2'b11;
endpackage

// File: rtl/clamp_timer.sv
module clamp_timer
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  output logic             active_o,
  output logic             end_o
);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] ZERO = '0;

  clamp_st_e        st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             hs_q;
  logic             fall;

  assign fall     = hs_q & ~hsync_i;
  assign active_o = (st_q == ST_ACTIVE);
  // restart wins over a window closing in the same cycle
  assign end_o    = (st_q == ST_ACTIVE) && (cnt_q <= ONE) && !fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= ZERO;
      hs_q  <= 1'b0;
    end else begin
      hs_q <= hsync_i;
      if (fall) begin
        if (dur_i == ZERO) begin
          st_q <= ST_IDLE;
        end else if (place_i == ZERO) begin
          st_q  <= ST_ACTIVE;
          cnt_q <= dur_i;
        end else begin
          st_q  <= ST_WAIT;
          cnt_q <= place_i;
        end
      end else begin
        unique case (st_q)
          ST_WAIT: begin
            if (cnt_q <= ONE) begin
              if (dur_i == ZERO) begin
                st_q <= ST_IDLE;
              end else begin
                st_q  <= ST_ACTIVE;
                cnt_q <= dur_i;
              end
            end else begin
              cnt_q <= cnt_q - ONE;
            end
          end
          ST_ACTIVE: begin
            if (cnt_q <= ONE) st_q <= ST_IDLE;
            else              cnt_q <= cnt_q - ONE;
          end
          default: st_q <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/ext_clamp_pol.sv
module ext_clamp_pol #(
  parameter int POL_W = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_i,
  input  logic ovr_i,
  input  logic high_i,
  output logic act_o,
  output logic end_o
);
  localparam logic [POL_W-1:0] ONE   = POL_W'(1);
  localparam logic [POL_W-1:0] MAXV  = '1;
  localparam logic [POL_W-1:0] START = POL_W'((1 << (POL_W-1)) - 1);

  logic [POL_W-1:0] lvl_q;
  logic             ext_q;
  logic             act_d_q;
  logic             pol_high;

  // pin mostly low -> active high
  assign pol_high = ovr_i ? high_i : ~lvl_q[POL_W-1];
  assign act_o    = (ext_q == pol_high);
  assign end_o    = act_d_q & ~act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q   <= START;
      ext_q   <= 1'b0;
      act_d_q <= 1'b0;
    end else begin
      ext_q   <= ext_i;
      act_d_q <= act_o;
      if (ext_q && lvl_q != MAXV)       lvl_q <= lvl_q + ONE;
      else if (!ext_q && lvl_q != '0)   lvl_q <= lvl_q - ONE;
    end
  end
endmodule

// File: rtl/offset_cadence.sv
module offset_cadence
  import clamp_pkg::*;
#(
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     clamp_end_i,
  input  logic     vsync_i,
  input  logic     en_i,
  input  logic     hold_i,
  input  cadence_e cad_i,
  output logic     upd_o
);
  localparam int CW = $clog2(DIV_B);
  localparam logic [CW-1:0] MASK_A = CW'(DIV_A - 1);
  localparam logic [CW-1:0] LAST_B = CW'(DIV_B - 1);
  localparam logic [CW-1:0] ONE    = CW'(1);

  logic [CW-1:0] cnt_q;
  logic          vs_pend_q;
  logic          done_q;
  logic          upd_q;
  logic          qual;
  logic          fire;

  always_comb begin
    unique case (cad_i)
      CAD_EVERY: qual = 1'b1;
      CAD_DIV_A: qual = ((cnt_q & MASK_A) == MASK_A);
      CAD_DIV_B: qual = (cnt_q == LAST_B);
      default:   qual = vs_pend_q;
    endcase
  end

  assign fire  = clamp_end_i & qual & (hold_i | ~done_q);
  assign upd_o = upd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      vs_pend_q <= 1'b0;
      done_q    <= 1'b0;
      upd_q     <= 1'b0;
    end else if (!en_i) begin
      cnt_q     <= '0;
      vs_pend_q <= 1'b0;
      done_q    <= 1'b0;
      upd_q     <= 1'b0;
    end else begin
      upd_q <= fire;
      if (clamp_end_i) cnt_q <= cnt_q + ONE;
      if (vsync_i)                         vs_pend_q <= 1'b1;
      else if (fire && cad_i == CAD_VSYNC) vs_pend_q <= 1'b0;
      if (hold_i)    done_q <= 1'b0;
      else if (fire) done_q <= 1'b1;
    end
  end
endmodule

// File: rtl/clamp_pulse_gen.sv
module clamp_pulse_gen
  import clamp_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int POL_W = 6,
  parameter int DIV_A = 16,
  parameter int DIV_B = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             hsync_i,
  input  logic             vsync_i,
  input  logic             ext_clamp_i,
  input  logic [CNT_W-1:0] place_i,
  input  logic [CNT_W-1:0] dur_i,
  input  logic             src_ext_i,
  input  logic             ext_pol_ovr_i,
  input  logic             ext_pol_high_i,
  input  logic             ao_en_i,
  input  logic             ao_hold_i,
  input  logic [1:0]       ao_cadence_i,
  output logic             clamp_o,
  output logic             offset_upd_o
);
  logic int_act, int_end, ext_act, ext_end, clamp_end;

  clamp_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hsync_i  (hsync_i),
    .place_i  (place_i),
    .dur_i    (dur_i),
    .active_o (int_act),
    .end_o    (int_end)
  );

  ext_clamp_pol #(.POL_W(POL_W)) u_ext (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ext_i  (ext_clamp_i),
    .ovr_i  (ext_pol_ovr_i),
    .high_i (ext_pol_high_i),
    .act_o  (ext_act),
    .end_o  (ext_end)
  );

  assign clamp_o   = src_ext_i ? ext_act : int_act;
  assign clamp_end = src_ext_i ? ext_end : int_end;

  offset_cadence #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_cad (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clamp_end_i (clamp_end),
    .vsync_i     (vsync_i),
    .en_i        (ao_en_i),
    .hold_i      (ao_hold_i),
    .cad_i       (cadence_e'(ao_cadence_i)),
    .upd_o       (offset_upd_o)
  );
endmodule

// File: rtl/clamp_pulse_gen_chk.sv
module clamp_pulse_gen_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_clamp_i,
  input logic [CNT_W-1:0] place_i,
  input logic [CNT_W-1:0] dur_i,
  input logic             src_ext_i,
  input logic             ext_pol_ovr_i,
  input logic             ext_pol_high_i,
  input logic             ao_en_i,
  input logic             clamp_o,
  input logic             offset_upd_o
);
  logic [CNT_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       run_q <= '0;
    else if (!clamp_o)                 run_q <= '0;
    else if (run_q != '1)              run_q <= run_q + (CNT_W+1)'(1);
  end

  p_len_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!src_ext_i && place_i != '0 && clamp_o) |-> (run_q < {1'b0, dur_i}));

  p_ext_follow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (src_ext_i && ext_pol_ovr_i && ext_pol_high_i) |-> (clamp_o == $past(ext_clamp_i)));

  p_upd_single_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_upd_o |=> !offset_upd_o);

  p_upd_enabled_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    offset_upd_o |-> $past(ao_en_i));

  p_upd_after_window_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (offset_upd_o && !src_ext_i && !$past(src_ext_i)) |-> ($past(clamp_o) && !clamp_o));
endmodule

bind clamp_pulse_gen clamp_pulse_gen_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .ext_clamp_i    (ext_clamp_i),
  .place_i        (place_i),
  .dur_i          (dur_i),
  .src_ext_i      (src_ext_i),
  .ext_pol_ovr_i  (ext_pol_ovr_i),
  .ext_pol_high_i (ext_pol_high_i),
  .ao_en_i        (ao_en_i),
  .clamp_o        (clamp_o),
  .offset_upd_o   (offset_upd_o)
);

// File: tb/sim_clamp_pulse_gen.sv
`timescale 1ns/1ps
module sim_clamp_pulse_gen;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       hsync_i = 1'b0, vsync_i = 1'b0, ext_clamp_i = 1'b0;
  logic [7:0] place_i = 8'd8, dur_i = 8'd32;
  logic       src_ext_i = 1'b0, ext_pol_ovr_i = 1'b0, ext_pol_high_i = 1'b1;
  logic       ao_en_i = 1'b0, ao_hold_i = 1'b1;
  logic [1:0] ao_cadence_i = 2'b11;
  logic       clamp_o, offset_upd_o;

  int n_checks = 0, n_fail = 0, n_upd = 0, base = 0;
  bit finished = 1'b0;

  always #4 clk_i = ~clk_i;

  clamp_pulse_gen u0 (.*);

  always @(negedge clk_i) if (offset_upd_o) n_upd <= n_upd + 1;

  // {placement, duration}
  localparam logic [15:0] VEC [6] = '{
    {8'd8, 8'd32}, {8'd0, 8'd1}, {8'd3, 8'd5},
    {8'd1, 8'd1},  {8'd10, 8'd0}, {8'd255, 8'd2}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic fall_edge();
    @(negedge clk_i) hsync_i = 1'b1;
    @(negedge clk_i) hsync_i = 1'b0;
  endtask

  task automatic scan(input int p, input int d, input bit upd_on, input string tag);
    int bad = 0, ubad = 0;
    for (int j = 0; j < p + d + 3; j++) begin
      @(negedge clk_i);
      if (clamp_o !== ((j >= p) && (j < p + d))) bad++;
      if (offset_upd_o !== (upd_on && d != 0 && j == p + d)) ubad++;
    end
    check(bad == 0, tag, bad, 0);
    check(ubad == 0, {tag, " R7 strobe"}, ubad, 0);
  endtask

  task automatic pulses(input int n);
    for (int k = 0; k < n; k++) begin
      fall_edge();
      repeat (4) @(negedge clk_i);
    end
  endtask

  task automatic upd_delta(input int exp, input string tag);
    #1;
    check((n_upd - base) == exp, tag, n_upd - base, exp);
  endtask

  task automatic rearm();
    @(negedge clk_i) ao_en_i = 1'b0;
    @(negedge clk_i) ao_en_i = 1'b1;
    #1 base = n_upd;
  endtask

  task automatic ext_check(input logic lvl, input logic exp, input string tag);
    @(negedge clk_i) ext_clamp_i = lvl;
    @(negedge clk_i);
    check(clamp_o === exp, tag, clamp_o, exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk_i);
    check(clamp_o === 1'b0 && offset_upd_o === 1'b0, "R11 in reset", {clamp_o, offset_upd_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(clamp_o === 1'b0 && offset_upd_o === 1'b0, "R11 after reset", {clamp_o, offset_upd_o}, 0);

    // R1 R2 R3 R7: placement/duration table, strobe every clamp
    ao_en_i = 1'b1; ao_hold_i = 1'b1; ao_cadence_i = 2'b00;
    foreach (VEC[i]) begin
      place_i = VEC[i][15:8];
      dur_i   = VEC[i][7:0];
      fall_edge();
      scan(VEC[i][15:8], VEC[i][7:0], 1'b1, $sformatf("R1/R2/R3 vec%0d", i));
    end

    // R4 restart while pending
    place_i = 8'd5; dur_i = 8'd4;
    fall_edge();
    repeat (2) @(negedge clk_i);
    fall_edge();
    scan(5, 4, 1'b1, "R4 pending");
    // R4 restart while active
    place_i = 8'd2; dur_i = 8'd10;
    fall_edge();
    repeat (4) @(negedge clk_i);
    check(clamp_o === 1'b1, "R4 active before restart", clamp_o, 1);
    fall_edge();
    scan(2, 10, 1'b1, "R4 active");

    // R7 disabled: no strobe
    place_i = 8'd0; dur_i = 8'd1;
    ao_en_i = 1'b0;
    #1 base = n_upd;
    pulses(3);
    upd_delta(0, "R7 disabled");

    // R8 cadence 01 (every 16) and 10 (every 64)
    ao_cadence_i = 2'b01;
    rearm();
    pulses(15); upd_delta(0, "R8 div16 15");
    pulses(1);  upd_delta(1, "R8 div16 16");
    pulses(16); upd_delta(2, "R8 div16 32");
    ao_cadence_i = 2'b10;
    rearm();
    pulses(63); upd_delta(0, "R8 div64 63");
    pulses(1);  upd_delta(1, "R8 div64 64");

    // R3 zero duration does not advance the cadence count
    ao_cadence_i = 2'b01;
    rearm();
    pulses(15);
    dur_i = 8'd0; pulses(5);
    upd_delta(0, "R3 zero dur no count");
    dur_i = 8'd1; pulses(1);
    upd_delta(1, "R3 16th real clamp");

    // R9 once per vsync
    ao_cadence_i = 2'b11;
    rearm();
    pulses(3); upd_delta(0, "R9 no vsync");
    @(negedge clk_i) vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
    pulses(2); upd_delta(1, "R9 first vsync");
    @(negedge clk_i) vsync_i = 1'b1;
    @(negedge clk_i) vsync_i = 1'b0;
    pulses(1); upd_delta(2, "R9 second vsync");

    // R10 one-time versus continuous
    ao_cadence_i = 2'b00; ao_hold_i = 1'b0;
    rearm();
    pulses(3); upd_delta(1, "R10 one-time");
    rearm();
    pulses(2); upd_delta(1, "R10 rearmed");
    ao_hold_i = 1'b1;
    #1 base = n_upd;
    pulses(2); upd_delta(2, "R10 continuous");

    // R5 external, forced polarity
    ao_en_i = 1'b0;
    src_ext_i = 1'b1; ext_pol_ovr_i = 1'b1; ext_pol_high_i = 1'b1;
    ext_check(1'b1, 1'b1, "R5 high active");
    ext_check(1'b0, 1'b0, "R5 high idle");
    ext_pol_high_i = 1'b0;
    ext_check(1'b0, 1'b1, "R5 low active");
    ext_check(1'b1, 1'b0, "R5 low idle");

    // R6 automatic polarity
    ext_pol_ovr_i = 1'b0;
    @(negedge clk_i) ext_clamp_i = 1'b0;
    repeat (70) @(negedge clk_i);
    ext_check(1'b1, 1'b1, "R6 mostly low active");
    ext_check(1'b0, 1'b0, "R6 mostly low idle");
    @(negedge clk_i) ext_clamp_i = 1'b1;
    repeat (70) @(negedge clk_i);
    ext_check(1'b1, 1'b0, "R6 mostly high idle");
    ext_check(1'b0, 1'b1, "R6 mostly high active");

    // R7 external window end drives the strobe
    ext_pol_ovr_i = 1'b1; ext_pol_high_i = 1'b1;
    @(negedge clk_i) ext_clamp_i = 1'b0;
    repeat (3) @(negedge clk_i);
    ao_cadence_i = 2'b00;
    rearm();
    @(negedge clk_i) ext_clamp_i = 1'b1;
    repeat (3) @(negedge clk_i);
    ext_clamp_i = 1'b0;
    repeat (5) @(negedge clk_i);
    upd_delta(1, "R7 external end");

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule